// File: doc/BRIEF.md
# Periodic Peripheral Autopoll Scheduler

This block paces automatic polling of a peripheral bus. While polling is enabled it counts whole milliseconds, derived from the core clock by a prescaler, and when the programmed interval has elapsed it raises a one-cycle poll strobe. The strobe carries the current 16-bit device mask, which tells the bus which of its sixteen addresses to service. The next interval starts at once, whether or not the poll returns anything.

When the bus answers with one or more bytes, the block frames them as an unsolicited packet for the host. The packet is a channel byte of 0x00, then a polled-data marker of 0x40, then the returned bytes in order. It streams out through a valid/ready byte interface. An answer of zero bytes produces nothing. An answer that arrives while a previous packet is still streaming is discarded.

The interval is a one-byte count of milliseconds and may not be zero. A rising enable, or a new rate written while polling, restarts the countdown from a full interval. A falling enable cancels the pending poll.

Top module: `autopoll_sched`

## Requirements
- R1: After reset the interval is 20 ms and poll_mask is 0xFFFF. poll_stb and pkt_valid are low.
- R2: After reset no poll is issued until poll_en is seen low and then high. An enable held high through reset does not start polling.
- R3: Take the clock edge at which poll_en is first sampled high after being low. The first poll_stb is visible after the edge that lies rate×CYC_PER_MS cycles later. Each later poll_stb follows the previous one by exactly rate×CYC_PER_MS cycles.
- R4: When poll_en goes low, the pending poll is cancelled. No poll_stb occurs while poll_en stays low.
- R5: A rate write with a nonzero value while polling restarts the countdown with the new period. This is timed as in R3, starting from the write edge.
- R6: A rate write with value zero is ignored. The countdown is not restarted and the old period stays.
- R7: A rate written while polling is off is used from the next enable.
- R8: A mask write changes poll_mask, which is presented with every later poll_stb. It does not disturb the poll timing.
- R9: An accepted response of N bytes yields the packet 0x00, 0x40, then byte 0 (rsp_data[7:0]), byte 1 (rsp_data[15:8]) and so on, N+2 bytes in all. pkt_last is high on the final byte only. pkt_valid falls after that byte is taken.
- R10: A response with rsp_len equal to 0 produces no packet.
- R11: While pkt_valid is high and pkt_ready is low, pkt_valid and pkt_data hold their values.
- R12: A response that arrives while a packet is still being sent is dropped. Only the earlier packet appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_en | input | 1 | Polling enable level |
| rate_wr | input | 1 | Strobe that writes rate_val |
| rate_val | input | RATE_W | Poll interval in milliseconds; zero is rejected |
| mask_wr | input | 1 | Strobe that writes mask_val |
| mask_val | input | MASK_W | Device mask to poll |
| poll_stb | output | 1 | One-cycle poll request |
| poll_mask | output | MASK_W | Device mask that goes with poll_stb |
| rsp_valid | input | 1 | Bus response present |
| rsp_len | input | LEN_W | Response byte count; values above MAX_BYTES are clamped |
| rsp_data | input | 8×MAX_BYTES | Response bytes, byte 0 in the low bits |
| pkt_valid | output | 1 | Outbound packet byte valid |
| pkt_ready | input | 1 | Host accepts the byte |
| pkt_data | output | 8 | Outbound packet byte |
| pkt_last | output | 1 | Final byte of the packet |

## Verification
The hardest case to reach is a rate rewrite that lands partway through a running countdown. The new period has to be measured from the write edge, not from the last poll. The stimulus lets one long default interval run, waits a fixed number of cycles into the next one, then writes a short rate. It then counts cycles to the next strobe, and afterwards checks that a zero write right after a poll leaves the spacing unchanged. The dropped-response case is reached by holding pkt_ready low so that a second response meets a packet that is still pending.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
   localparam logic [7:0] HDR_CHANNEL = 8'h00;
   localparam logic [7:0] HDR_POLLED  = 8'h40;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_HDR0,
      FR_HDR1,
      FR_BODY
   } frame_st_e;
endpackage

// File: rtl/ap_ms_prescaler.sv
module ap_ms_prescaler #(
   parameter int CYC_PER_MS = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (CYC_PER_MS == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int PW = $clog2(CYC_PER_MS);
      localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);
      logic [PW-1:0] pre_q;

      assign tick = run && (pre_q == LAST);

      always_ff @(posedge clk) begin
         if (!rst_n || !run) pre_q <= '0;
         else if (tick)      pre_q <= '0;
         else                pre_q <= pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/ap_interval_timer.sv
module ap_interval_timer #(
   parameter int CYC_PER_MS = 50000,
   parameter int RATE_W     = 8,
   parameter int RESET_RATE = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll_en,
   input  logic              rate_wr,
   input  logic [RATE_W-1:0] rate_val,
   output logic              poll_stb
);
   localparam logic [RATE_W-1:0] RATE_INIT = RATE_W'(RESET_RATE);
   localparam logic [RATE_W-1:0] ONE       = RATE_W'(1);

   logic              en_q, armed_q, stb_q, tick;
   logic [RATE_W-1:0] rate_q, ms_q, rate_nxt;
   logic              wr_ok, rise, fall, restart, run;

   assign wr_ok    = rate_wr && (rate_val != '0);
   assign rate_nxt = wr_ok ? rate_val : rate_q;
   assign rise     = poll_en && !en_q;
   assign fall     = !poll_en && en_q;
   assign restart  = rise || (armed_q && poll_en && wr_ok);
   assign run      = armed_q && poll_en && !restart;

   ap_ms_prescaler #(.CYC_PER_MS(CYC_PER_MS)) i_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b1;
         armed_q <= 1'b0;
         rate_q  <= RATE_INIT;
         ms_q    <= RATE_INIT;
         stb_q   <= 1'b0;
      end else begin
         en_q   <= poll_en;
         rate_q <= rate_nxt;
         stb_q  <= tick && (ms_q == ONE);
         if (rise)      armed_q <= 1'b1;
         else if (fall) armed_q <= 1'b0;
         if (restart)   ms_q <= rate_nxt;
         else if (tick) ms_q <= (ms_q == ONE) ? rate_nxt : ms_q - 1'b1;
      end
   end

   assign poll_stb = stb_q;

   assert_zero_rate_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_wr && rate_val == '0) |=> $stable(rate_q));
   always_ff @(posedge clk)
      if (rst_n) assert_rate_nonzero_R6: assert (rate_q != '0);
endmodule

// File: rtl/ap_packet_framer.sv
module ap_packet_framer
   import autopoll_pkg::*;
#(
   parameter int MAX_BYTES = 8,
   parameter int LEN_W     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rsp_valid,
   input  logic [LEN_W-1:0]       rsp_len,
   input  logic [8*MAX_BYTES-1:0] rsp_data,
   output logic                   pkt_valid,
   input  logic                   pkt_ready,
   output logic [7:0]             pkt_data,
   output logic                   pkt_last
);
   localparam logic [LEN_W-1:0] MAXB = LEN_W'(MAX_BYTES);

   frame_st_e              st_q;
   logic [LEN_W-1:0]       len_q, idx_q, len_cl;
   logic [8*MAX_BYTES-1:0] buf_q;
   logic                   accept, at_end;

   assign len_cl = (rsp_len > MAXB) ? MAXB : rsp_len;
   assign accept = rsp_valid && (st_q == FR_IDLE) && (rsp_len != '0);
   assign at_end = (idx_q == len_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= FR_IDLE;
         len_q <= '0;
         idx_q <= '0;
         buf_q <= '0;
      end else begin
         case (st_q)
            FR_IDLE: if (accept) begin
               st_q  <= FR_HDR0;
               len_q <= len_cl;
               idx_q <= '0;
               buf_q <= rsp_data;
            end
            FR_HDR0: if (pkt_ready) st_q <= FR_HDR1;
            FR_HDR1: if (pkt_ready) st_q <= FR_BODY;
            FR_BODY: if (pkt_ready) begin
               if (at_end) st_q <= FR_IDLE;
               else        idx_q <= idx_q + 1'b1;
            end
            default: st_q <= FR_IDLE;
         endcase
      end
   end

   always_comb begin
      pkt_valid = (st_q != FR_IDLE);
      pkt_last  = (st_q == FR_BODY) && at_end;
      case (st_q)
         FR_HDR0: pkt_data = HDR_CHANNEL;
         FR_HDR1: pkt_data = HDR_POLLED;
         FR_BODY: pkt_data = buf_q[idx_q*8 +: 8];
         default: pkt_data = 8'h00;
      endcase
   end

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));
   assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_ready && pkt_last) |=> !pkt_valid);
   assert_empty_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_len == '0 && !pkt_valid) |=> !pkt_valid);
endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched #(
   parameter int               CYC_PER_MS = 50000,
   parameter int               RATE_W     = 8,
   parameter int               RESET_RATE = 20,
   parameter int               MASK_W     = 16,
   parameter logic [MASK_W-1:0] RESET_MASK = '1,
   parameter int               MAX_BYTES  = 8,
   localparam int              LEN_W      = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   poll_en,
   input  logic                   rate_wr,
   input  logic [RATE_W-1:0]      rate_val,
   input  logic                   mask_wr,
   input  logic [MASK_W-1:0]      mask_val,
   output logic                   poll_stb,
   output logic [MASK_W-1:0]      poll_mask,
   input  logic                   rsp_valid,
   input  logic [LEN_W-1:0]       rsp_len,
   input  logic [8*MAX_BYTES-1:0] rsp_data,
   output logic                   pkt_valid,
   input  logic                   pkt_ready,
   output logic [7:0]             pkt_data,
   output logic                   pkt_last
);
   if (CYC_PER_MS < 1) begin : g_bad_pre
      $error("CYC_PER_MS must be at least 1");
   end
   if (RESET_RATE < 1 || RESET_RATE >= (1 << RATE_W)) begin : g_bad_rate
      $error("RESET_RATE must be nonzero and fit RATE_W");
   end
   if (MAX_BYTES < 1) begin : g_bad_len
      $error("MAX_BYTES must be at least 1");
   end

   logic [MASK_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= RESET_MASK;
      else if (mask_wr) mask_q <= mask_val;
   end
   assign poll_mask = mask_q;

   ap_interval_timer #(
      .CYC_PER_MS(CYC_PER_MS),
      .RATE_W    (RATE_W),
      .RESET_RATE(RESET_RATE)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .poll_en (poll_en),
      .rate_wr (rate_wr),
      .rate_val(rate_val),
      .poll_stb(poll_stb)
   );

   ap_packet_framer #(
      .MAX_BYTES(MAX_BYTES),
      .LEN_W    (LEN_W)
   ) i_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rsp_valid(rsp_valid),
      .rsp_len  (rsp_len),
      .rsp_data (rsp_data),
      .pkt_valid(pkt_valid),
      .pkt_ready(pkt_ready),
      .pkt_data (pkt_data),
      .pkt_last (pkt_last)
   );

   assert_poll_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      poll_stb |-> $past(poll_en));
endmodule

// File: tb/test_autopoll_sched.sv
module test_autopoll_sched;
   localparam int CLK_PERIOD = 10;
   localparam int P   = 4;
   localparam int MB  = 4;
   localparam int LW  = $clog2(MB + 1);
   localparam int NV  = 4;
   localparam logic [LW-1:0] T_LEN [NV] = '{3'd1, 3'd2, 3'd4, 3'd3};
   localparam logic [31:0]   T_DAT [NV] = '{32'h0000_005A, 32'h0000_C312,
                                            32'hDEAD_BEEF, 32'h0011_2233};
   localparam int            T_TOT [NV] = '{3, 4, 6, 5};

   logic clk = 0, rst_n = 0, poll_en = 0, rate_wr = 0, mask_wr = 0;
   logic [7:0] rate_val = 0;
   logic [15:0] mask_val = 0;
   logic rsp_valid = 0, pkt_ready = 0;
   logic [LW-1:0] rsp_len = 0;
   logic [8*MB-1:0] rsp_data = 0;
   logic poll_stb, pkt_valid, pkt_last;
   logic [15:0] poll_mask;
   logic [7:0] pkt_data;

   int errors = 0, checks = 0, cyc = 0;
   bit done = 0;
   logic [7:0] got [16];
   int got_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   autopoll_sched #(.CYC_PER_MS(P), .MAX_BYTES(MB)) i_autopoll_sched (
      .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .rate_wr(rate_wr),
      .rate_val(rate_val), .mask_wr(mask_wr), .mask_val(mask_val),
      .poll_stb(poll_stb), .poll_mask(poll_mask), .rsp_valid(rsp_valid),
      .rsp_len(rsp_len), .rsp_data(rsp_data), .pkt_valid(pkt_valid),
      .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_last(pkt_last));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_poll(output int n, input int limit);
      n = 0;
      while (n < limit) begin
         @(posedge clk); n++;
         @(negedge clk); rate_wr = 0; mask_wr = 0;
         if (poll_stb) return;
      end
      n = -1;
   endtask

   task automatic count_polls(input int cycles, output int polls);
      polls = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (poll_stb) polls++;
      end
   endtask

   task automatic collect();
      got_n = 0;
      pkt_ready = 1;
      for (int t = 0; t < 40; t++) begin
         if (pkt_valid) begin
            if (got_n < 16) got[got_n] = pkt_data;
            got_n++;
            if (pkt_last) begin @(posedge clk); break; end
         end
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic send(input logic [LW-1:0] len, input logic [31:0] dat);
      rsp_valid = 1; rsp_len = len; rsp_data = dat;
      @(negedge clk);
      rsp_valid = 0;
   endtask

   initial begin
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 200000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
         end
      end
   end

   initial begin
      int n, polls;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!poll_stb && !pkt_valid, "R1 outputs idle", {poll_stb, pkt_valid}, 0);
      check(poll_mask == 16'hFFFF, "R1 mask", poll_mask, 16'hFFFF);
      rst_n = 1;
      @(negedge clk);
      // R1, R3: default rate of 20 ms
      poll_en = 1;
      wait_poll(n, 2000);
      check(n == 20*P + 1, "R1 R3 first poll", n, 20*P + 1);
      check(poll_mask == 16'hFFFF, "R1 mask at poll", poll_mask, 16'hFFFF);
      wait_poll(n, 2000);
      check(n == 20*P, "R3 interval", n, 20*P);
      // R5: rewrite mid countdown
      repeat (30) @(negedge clk);
      rate_wr = 1; rate_val = 8'd3;
      wait_poll(n, 2000);
      check(n == 3*P + 1, "R5 restart", n, 3*P + 1);
      wait_poll(n, 2000);
      check(n == 3*P, "R5 new period", n, 3*P);
      // R6: zero rate ignored
      rate_wr = 1; rate_val = 8'd0;
      wait_poll(n, 2000);
      check(n == 3*P, "R6 zero ignored", n, 3*P);
      // R8: mask write, timing unchanged
      mask_wr = 1; mask_val = 16'hA5C3;
      wait_poll(n, 2000);
      check(n == 3*P, "R8 timing", n, 3*P);
      check(poll_mask == 16'hA5C3, "R8 mask", poll_mask, 16'hA5C3);
      // R4: disable cancels
      repeat (5) @(negedge clk);
      poll_en = 0;
      count_polls(40, polls);
      check(polls == 0, "R4 no poll while off", polls, 0);
      // R7: rate written while off
      rate_wr = 1; rate_val = 8'd5;
      @(negedge clk); rate_wr = 0;
      poll_en = 1;
      wait_poll(n, 2000);
      check(n == 5*P + 1, "R7 rate from off", n, 5*P + 1);
      // R9: table of responses
      for (int v = 0; v < NV; v++) begin
         send(T_LEN[v], T_DAT[v]);
         collect();
         check(got_n == T_TOT[v], "R9 length", got_n, T_TOT[v]);
         check(got[0] == 8'h00, "R9 channel byte", got[0], 0);
         check(got[1] == 8'h40, "R9 polled marker", got[1], 8'h40);
         for (int b = 0; b < int'(T_LEN[v]); b++)
            check(got[2+b] == T_DAT[v][b*8 +: 8], "R9 payload", got[2+b], T_DAT[v][b*8 +: 8]);
      end
      // R10: empty response
      send('0, 32'hFFFF_FFFF);
      polls = 0;
      for (int i = 0; i < 10; i++) begin
         if (pkt_valid) polls++;
         @(negedge clk);
      end
      check(polls == 0, "R10 no packet", polls, 0);
      // R11, R12: back-pressure and drop
      pkt_ready = 0;
      send(3'd2, 32'h0000_BEEF);
      send(3'd1, 32'h0000_0077);
      @(negedge clk);
      check(pkt_valid && pkt_data == 8'h00, "R11 held", pkt_data, 0);
      collect();
      check(got_n == 4, "R12 first packet only", got_n, 4);
      check(got[2] == 8'hEF && got[3] == 8'hBE, "R12 payload", {got[3], got[2]}, 16'hBEEF);
      polls = 0;
      for (int i = 0; i < 10; i++) begin
         if (pkt_valid) polls++;
         @(negedge clk);
      end
      check(polls == 0, "R12 second dropped", polls, 0);
      // R2: enable held through reset
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      count_polls(100, polls);
      check(polls == 0, "R2 no poll after reset", polls, 0);
      check(poll_mask == 16'hFFFF, "R1 mask restored", poll_mask, 16'hFFFF);
      poll_en = 0;
      @(negedge clk);
      poll_en = 1;
      wait_poll(n, 2000);
      check(n == 20*P + 1, "R1 R2 rate restored", n, 20*P + 1);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule